// File: doc/BRIEF.md
# Mixed-Width Dual-Clock RAM

This block is a two-port memory whose two ports see different word widths. Port A writes narrow words of `WIDTH_D` bits. Both ports read wide words made of `RATIO` narrow lanes placed side by side. The storage holds `NUM_ENTRIES` narrow entries in total. It is split into `RATIO` independent banks, and each bank holds `NUM_ENTRIES/RATIO` rows.

A narrow write address is split into two fields:

- the lane field picks the bank;
- the row field addresses the row inside every bank.

A one-hot decoder turns the lane field and the write strobe into one enable per bank. All banks see the same row and the same write data, so only the decoded enable decides which bank stores the word.

Port B presents a row address on its own clock and receives every lane of that row in one access. Port A also returns the wide row that contains its current narrow address. A typical use is a narrow producer filling a buffer that a wide consumer drains in another clock domain.

Top module: `mwram_mixed`

## Requirements
- R1: Narrow address `r*RATIO+i` is stored in lane `i` of wide row `r`. Lane `i` occupies bits `[(i+1)*WIDTH_D-1 : i*WIDTH_D]` of both wide read outputs.
- R2: The low `log2(RATIO)` bits of `a_addr` select the lane. The remaining high bits select the row.
- R3: A write takes place only on a rising `clk_a` edge with `a_we` high. With `a_we` low, no entry changes, whatever the values on `a_addr` and `a_wdata`.
- R4: A write changes exactly one narrow entry. The other lanes of the same row and all other rows keep their contents.
- R5: `b_rdata` shows the whole row `b_addr` one `clk_b` edge after that address is sampled.
- R6: `a_rdata` shows the wide row that holds `a_addr` one `clk_a` edge after that address is sampled.
- R7: When port A reads a row in the same cycle as it writes into that row, `a_rdata` returns the old contents. The new word appears on the next read of that row.
- R8: Reset is synchronous and active high. `rst_a` clears `a_rdata` and `rst_b` clears `b_rdata` at the next edge of each port's own clock. Neither reset erases stored data.
- R9: The two ports run on independent clocks. A word written on port A is returned by port B on any `clk_b` read sampled after the write edge.

Configuration limits: `RATIO` must be a power of two and at least 2. `NUM_ENTRIES` must be divisible by `RATIO`, with at least two rows per bank. Elaboration stops with an error if these do not hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_addr | input | log2(NUM_ENTRIES) | Narrow address: row in high bits, lane in low bits |
| a_wdata | input | WIDTH_D | Narrow write data |
| a_we | input | 1 | Write strobe |
| a_rdata | output | WIDTH_D*RATIO | Wide row read on port A |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_addr | input | log2(NUM_ENTRIES/RATIO) | Wide row address |
| b_rdata | output | WIDTH_D*RATIO | Wide row read on port B |

## Verification
A bad enable decode or a wrong address split puts a narrow word in the wrong lane or the wrong row. That wrong word shows up on the first wide read of the affected row, one edge after that row is addressed on either port. Swapped lane placement corrupts every wide read that follows a non-uniform fill. A write-through read path, or a write that fires while the strobe is low, appears on `a_rdata` on the very next `clk_a` read of that row. Comparing both outputs against a reference model on every edge catches each of these within a few cycles of its cause.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    // Power-of-two test used for the configuration guard.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Index width that never drops to zero.
    function automatic int field_w(input int v);
        return (v <= 1) ? 1 : $clog2(v);
    endfunction

    // Port A operation kind, carried with the split address.
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } a_op_e;

endpackage

// File: rtl/mwram_lane_dec.sv
module mwram_lane_dec #(
    parameter int RATIO = 4,
    parameter int SEL_W = 2
) (
    input  logic             wr,
    input  logic [SEL_W-1:0] lane,
    output logic [RATIO-1:0] en
);
    // One enable per bank; at most one is high.
    for (genvar i = 0; i < RATIO; i++) begin : g_en
        assign en[i] = wr && (lane == SEL_W'(i));
    end
endmodule

// File: rtl/mwram_bank.sv
module mwram_bank #(
    parameter int WIDTH_D = 8,
    parameter int DEPTH   = 16,
    parameter int ROW_W   = 4
) (
    input  logic               clk_a,
    input  logic               rst_a,
    input  logic               we,
    input  logic [ROW_W-1:0]   row_a,
    input  logic [WIDTH_D-1:0] wdata,
    output logic [WIDTH_D-1:0] q_a,
    input  logic               clk_b,
    input  logic               rst_b,
    input  logic [ROW_W-1:0]   row_b,
    output logic [WIDTH_D-1:0] q_b
);
    logic [WIDTH_D-1:0] store [DEPTH];

    // Write and read share the edge, so the read returns the previous contents.
    always_ff @(posedge clk_a) begin
        if (we) begin
            store[row_a] <= wdata;
        end
        if (rst_a) begin
            q_a <= '0;
        end else begin
            q_a <= store[row_a];
        end
    end

    always_ff @(posedge clk_b) begin
        if (rst_b) begin
            q_b <= '0;
        end else begin
            q_b <= store[row_b];
        end
    end

    // R7
    new_data_next_read_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (we ##1 (row_a == $past(row_a))) |=> (q_a == $past(wdata, 2)));

endmodule

// File: rtl/mwram_mixed.sv
module mwram_mixed #(
    parameter int WIDTH_D     = 8,
    parameter int RATIO       = 4,
    parameter int NUM_ENTRIES = 64,
    localparam int ROWS   = NUM_ENTRIES / RATIO,
    localparam int SEL_W  = mwram_pkg::field_w(RATIO),
    localparam int ROW_W  = mwram_pkg::field_w(ROWS),
    localparam int ADDR_W = mwram_pkg::field_w(NUM_ENTRIES),
    localparam int WIDE_W = WIDTH_D * RATIO
) (
    input  logic               clk_a,
    input  logic               rst_a,
    input  logic [ADDR_W-1:0]  a_addr,
    input  logic [WIDTH_D-1:0] a_wdata,
    input  logic               a_we,
    output logic [WIDE_W-1:0]  a_rdata,
    input  logic               clk_b,
    input  logic               rst_b,
    input  logic [ROW_W-1:0]   b_addr,
    output logic [WIDE_W-1:0]  b_rdata
);
    import mwram_pkg::*;

    if (!is_pow2(RATIO) || RATIO < 2 || (NUM_ENTRIES % RATIO) != 0 || ROWS < 2)
    begin : g_bad_cfg
        $error("mwram_mixed: RATIO must be a power of two >= 2 dividing NUM_ENTRIES");
    end

    typedef struct packed {
        a_op_e            op;
        logic [ROW_W-1:0] row;
        logic [SEL_W-1:0] lane;
    } a_req_t;

    a_req_t           req;
    logic [RATIO-1:0] lane_en;
    logic [WIDTH_D-1:0] q_a [RATIO];
    logic [WIDTH_D-1:0] q_b [RATIO];

    assign req = a_req_t'({a_we, a_addr});

    mwram_lane_dec #(
        .RATIO (RATIO),
        .SEL_W (SEL_W)
    ) u_dec (
        .wr   (req.op == OP_WRITE),
        .lane (req.lane),
        .en   (lane_en)
    );

    for (genvar i = 0; i < RATIO; i++) begin : g_bank
        mwram_bank #(
            .WIDTH_D (WIDTH_D),
            .DEPTH   (ROWS),
            .ROW_W   (ROW_W)
        ) u_bank (
            .clk_a (clk_a),
            .rst_a (rst_a),
            .we    (lane_en[i]),
            .row_a (req.row),
            .wdata (a_wdata),
            .q_a   (q_a[i]),
            .clk_b (clk_b),
            .rst_b (rst_b),
            .row_b (b_addr),
            .q_b   (q_b[i])
        );
        assign a_rdata[i*WIDTH_D +: WIDTH_D] = q_a[i];
        assign b_rdata[i*WIDTH_D +: WIDTH_D] = q_b[i];
    end

    // R3
    idle_no_enable_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        !a_we |-> (lane_en == '0));

    // R2
    lane_select_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        a_we |-> lane_en[a_addr[SEL_W-1:0]]);

    // R4
    single_bank_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        a_we |-> $onehot(lane_en));

endmodule

// File: tb/mwram_mixed_tb.sv
module mwram_mixed_tb;
    localparam int W  = 8;
    localparam int R  = 4;
    localparam int N  = 64;
    localparam int NR = N / R;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_a, rst_b, a_we;
    logic [5:0] a_addr;
    logic [3:0] b_addr;
    logic [W-1:0] a_wdata;
    logic [W*R-1:0] a_rdata, b_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string tag_a = "R8";
    string tag_b = "R8";

    mwram_mixed #(.WIDTH_D(W), .RATIO(R), .NUM_ENTRIES(N)) u_dut (
        .clk_a(clk_a), .rst_a(rst_a), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_we(a_we), .a_rdata(a_rdata), .clk_b(clk_b), .rst_b(rst_b),
        .b_addr(b_addr), .b_rdata(b_rdata)
    );

    // 250 MHz on both ports, port B offset by 1 ns so edges never coincide.
    always #2 clk_a = ~clk_a;
    initial begin
        #1;
        forever #2 clk_b = ~clk_b;
    end

    // Reference model: flat narrow array plus known flags.
    logic [W-1:0] ref_mem [N];
    bit           ref_ok  [N];
    logic [W*R-1:0] exp_a = '0, exp_b = '0, msk_a = '0, msk_b = '0;

    initial begin
        for (int k = 0; k < N; k++) ref_ok[k] = 1'b0;
    end

    function automatic void wide_row(input int row, output logic [W*R-1:0] d,
                                     output logic [W*R-1:0] m);
        d = '0;
        m = '0;
        for (int i = 0; i < R; i++) begin
            if (ref_ok[row*R+i]) begin
                d[i*W +: W] = ref_mem[row*R+i];
                m[i*W +: W] = '1;
            end
        end
    endfunction

    always @(posedge clk_a) begin
        if (rst_a) begin
            exp_a = '0;
            msk_a = '1;
        end else begin
            wide_row(int'(a_addr) / R, exp_a, msk_a);
        end
        if (a_we) begin
            ref_mem[a_addr] = a_wdata;
            ref_ok[a_addr]  = 1'b1;
        end
    end

    always @(posedge clk_b) begin
        if (rst_b) begin
            exp_b = '0;
            msk_b = '1;
        end else begin
            wide_row(int'(b_addr), exp_b, msk_b);
        end
    end

    always @(negedge clk_a) begin
        if (!done && msk_a != '0) begin
            tests++;
            if ((a_rdata & msk_a) !== (exp_a & msk_a)) begin
                fails++;
                $display("FAIL %s port A: got %h expected %h (mask %h)",
                         tag_a, a_rdata, exp_a, msk_a);
            end
        end
    end

    always @(negedge clk_b) begin
        if (!done && msk_b != '0) begin
            tests++;
            if ((b_rdata & msk_b) !== (exp_b & msk_b)) begin
                fails++;
                $display("FAIL %s port B: got %h expected %h (mask %h)",
                         tag_b, b_rdata, exp_b, msk_b);
            end
        end
    end

    task automatic a_cycle(input logic we, input int addr, input logic [W-1:0] d);
        @(negedge clk_a);
        a_we    = we;
        a_addr  = 6'(addr);
        a_wdata = d;
    endtask

    // Port B sweeps rows continuously with a stride coprime to the row count.
    initial begin
        b_addr = '0;
        forever begin
            @(negedge clk_b);
            b_addr = b_addr + 4'd5;
        end
    end

    initial begin
        rst_a = 1'b1;
        rst_b = 1'b1;
        a_we = 1'b0;
        a_addr = '0;
        a_wdata = '0;
        // R8: outputs are zero while in reset
        repeat (4) a_cycle(1'b0, 0, '0);
        rst_a = 1'b0;
        rst_b = 1'b0;

        // R1 / R9: fill every narrow address; port B reads across the clock boundary
        tag_a = "R1";
        tag_b = "R9";
        for (int k = 0; k < N; k++) a_cycle(1'b1, k, W'(k * 37 + 5));

        // R5: port B sweeps rows while port A idles
        tag_b = "R5";
        tag_a = "R6";
        for (int k = 0; k < 40; k++) a_cycle(1'b0, (k * 7) % N, '0);

        // R3: strobe low with changing address and data must leave contents intact
        tag_a = "R3";
        tag_b = "R3";
        for (int k = 0; k < 24; k++) a_cycle(1'b0, (k * 11) % N, 8'hEE);

        // R2: refill in descending order with a new pattern
        tag_a = "R2";
        tag_b = "R2";
        for (int k = N - 1; k >= 0; k--) a_cycle(1'b1, k, W'(k * 13 + 100));

        // R4: one lane of row 5 changes; neighbours read back unchanged
        tag_a = "R4";
        tag_b = "R4";
        a_cycle(1'b1, 5 * R + 2, 8'hA5);
        for (int k = 0; k < 8; k++) a_cycle(1'b0, 5 * R + (k % R), '0);
        a_cycle(1'b0, 4 * R, '0);
        a_cycle(1'b0, 6 * R + 3, '0);

        // R7: back-to-back writes to one address return old data first
        tag_a = "R7";
        a_cycle(1'b1, 9, 8'h11);
        a_cycle(1'b1, 9, 8'h22);
        a_cycle(1'b1, 10, 8'h33);
        a_cycle(1'b0, 9, '0);
        a_cycle(1'b0, 9, '0);

        // R6: port A reads each row through a varied lane address
        tag_a = "R6";
        for (int r = 0; r < NR; r++) a_cycle(1'b0, r * R + (r % R), '0);

        // R8: mid-run reset clears outputs but keeps contents
        tag_a = "R8";
        tag_b = "R8";
        rst_a = 1'b1;
        rst_b = 1'b1;
        repeat (3) a_cycle(1'b0, 21, '0);
        rst_a = 1'b0;
        rst_b = 1'b0;
        for (int r = 0; r < NR + 4; r++) a_cycle(1'b0, (r % NR) * R, '0);

        repeat (4) a_cycle(1'b0, 0, '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule